// File: doc/BRIEF.md
# Oscillator Frequency Measurement Counter

This block is a self-test aid that measures a free-running test oscillator against the system clock. Software writes a measurement window, given as a number of system-clock cycles, through a small register port. The block then counts that window down one cycle at a time. While the window is still open, it counts the rising edges of the oscillator. Software can read back three values: the cycles still left in the window, the number of pulses counted so far, and a flag that reports whether the oscillator has reached a fixed toggle threshold.

The oscillator arrives asynchronously. It passes through a synchronizer chain and an edge detector before it reaches the counter. The oscillator itself and any pass/fail limits other than the toggle threshold are left to the surrounding logic.

Top module: `osc_meas`

## Requirements
- R1: After reset, reads of the window (address 0), the pulse count (address 1) and the status (address 2) all return zero.
- R2: A write to address 0 loads the low WIN_W bits of the write data into the window counter and ignores the upper bits. At the next read, address 0 returns the loaded value.
- R3: A read of address 0 returns the cycles remaining. The window counter drops by one on each clock while it is non-zero and holds at zero once it gets there.
- R4: Oscillator rising edges are counted only while the window counter is non-zero. Address 1 returns the count in its low CNT_W bits and zeros above them.
- R5: The oscillator passes through SYNC_STAGES flops (default 2) and then an edge detector. A low-to-high change first sampled at one clock edge raises the count at the third clock edge, counting that first edge as the first.
- R6: The pulse count saturates at 2^CNT_W-1 and does not wrap.
- R7: Status bit 0 at address 2 becomes 1 in the cycle the count reaches TOGGLE_THRESH (default 0x400). It then stays at 1 until the next window write or reset. All other status bits read 0.
- R8: A window write clears the pulse count and the status flag and starts a new measurement, even if a measurement is already running.
- R9: Writes to addresses 1, 2 and 3 change nothing. Reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscIn | input | 1 | Asynchronous test oscillator |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 window, 1 count, 2 status, 3 unused) |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |

## Verification
The bench builds the block with a 10-bit window, a 6-bit pulse counter and a toggle threshold of 12. With these values, saturation at 63 and the sticky flag can both be reached within a few hundred cycles. The truncation of the window write, the hold at zero and a restart in the middle of a measurement each need only short windows. A behavioural reference model, driven by a history of oscillator samples, is compared with the read port on every clock while the address rotates. Directed steps also pin down the synchronizer latency.

// File: rtl/osc_meas_pkg.sv
package osc_meas_pkg;
  localparam logic [1:0] ADDR_WIN    = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  typedef struct packed {
    logic clearMeas;   // new window written: restart measurement
    logic countPulse;  // qualified oscillator rising edge
  } measStrobes_t;
endpackage

// File: rtl/osc_meas_ctrl.sv
module osc_meas_ctrl
  import osc_meas_pkg::*;
#(
  parameter int WIN_W       = 18,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [WIN_W-1:0]  winLeft,
  output measStrobes_t      strobes
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic              oscPrev;
  logic              oscRise;
  logic              loadHit;
  logic              winOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      oscPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_MSB-1:0], oscIn};
      oscPrev <= syncQ[SYNC_MSB];
    end
  end

  assign oscRise = syncQ[SYNC_MSB] & ~oscPrev;
  assign loadHit = regWrEn && (regAddr == ADDR_WIN);
  assign winOpen = (winLeft != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winLeft <= '0;
    end else if (loadHit) begin
      winLeft <= regWrData[WIN_W-1:0];
    end else if (winOpen) begin
      winLeft <= winLeft - 1'b1;
    end
  end

  always_comb begin
    strobes.clearMeas  = loadHit;
    strobes.countPulse = oscRise && winOpen && !loadHit;
  end

  // R2
  win_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadHit |=> winLeft == $past(regWrData[WIN_W-1:0]));

  // R3
  win_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadHit && winLeft != '0) |=> winLeft == $past(winLeft) - 1'b1);

  // R3
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadHit && winLeft == '0) |=> winLeft == '0);
endmodule

// File: rtl/osc_meas_dp.sv
module osc_meas_dp
  import osc_meas_pkg::*;
#(
  parameter int CNT_W         = 20,
  parameter int TOGGLE_THRESH = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  measStrobes_t     strobes,
  output logic [CNT_W-1:0] pulseCnt,
  output logic             threshHit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] THR_M1  = CNT_W'(TOGGLE_THRESH - 1);

  logic cntFull;
  assign cntFull = (pulseCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      threshHit <= 1'b0;
    end else if (strobes.clearMeas) begin
      pulseCnt  <= '0;
      threshHit <= 1'b0;
    end else if (strobes.countPulse) begin
      if (!cntFull) pulseCnt <= pulseCnt + 1'b1;
      if (pulseCnt == THR_M1) threshHit <= 1'b1;
    end
  end

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clearMeas && pulseCnt == CNT_MAX) |=> pulseCnt == CNT_MAX);

  // R8
  clear_meas_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearMeas |=> (pulseCnt == '0 && !threshHit));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (threshHit && !strobes.clearMeas) |=> threshHit);

  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.countPulse && !strobes.clearMeas) |=> $stable(pulseCnt));
endmodule

// File: rtl/osc_meas.sv
module osc_meas
  import osc_meas_pkg::*;
#(
  parameter int WIN_W         = 18,
  parameter int CNT_W         = 20,
  parameter int TOGGLE_THRESH = 1024,
  parameter int SYNC_STAGES   = 2,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  measStrobes_t     strobes;
  logic [WIN_W-1:0] winLeft;
  logic [CNT_W-1:0] pulseCnt;
  logic             threshHit;

  osc_meas_ctrl #(
    .WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData),
    .winLeft(winLeft), .strobes(strobes)
  );

  osc_meas_dp #(
    .CNT_W(CNT_W), .TOGGLE_THRESH(TOGGLE_THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pulseCnt(pulseCnt), .threshHit(threshHit)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_WIN:    regRdData = {{(DATA_W-WIN_W){1'b0}}, winLeft};
      ADDR_COUNT:  regRdData = {{(DATA_W-CNT_W){1'b0}}, pulseCnt};
      ADDR_STATUS: regRdData = {{(DATA_W-1){1'b0}}, threshHit};
      default:     regRdData = '0;
    endcase
  end

  // R1
  rst_state_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (winLeft == '0 && pulseCnt == '0 && !threshHit));
endmodule

// File: tb/osc_meas_tb.sv
module osc_meas_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W  = 10;
  localparam int CNT_W  = 6;
  localparam int THR    = 12;
  localparam int CNT_MX = 63;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oscIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mWin = 0;
  int mCnt = 0;
  bit mFlag = 0;
  bit h0 = 0, h1 = 0, h2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_meas #(
    .WIN_W(WIN_W), .CNT_W(CNT_W), .TOGGLE_THRESH(THR),
    .SYNC_STAGES(2), .DATA_W(32)
  ) u_dut (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  // behavioural reference: h0/h1/h2 = oscillator samples one, two, three edges back
  always @(posedge clk) begin
    bit rise;
    if (!rstN) begin
      mWin = 0; mCnt = 0; mFlag = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      rise = h1 && !h2;
      if (regWrEn && regAddr == 2'd0) begin
        mWin = int'(regWrData % (1 << WIN_W));
        mCnt = 0;
        mFlag = 0;
      end else if (mWin != 0) begin
        if (rise && mCnt < CNT_MX) mCnt++;
        if (mCnt >= THR) mFlag = 1;
        mWin--;
      end
      h2 = h1; h1 = h0; h0 = oscIn;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] exp;
    string tag;
    case (regAddr)
      2'd0: begin exp = 32'(mWin); tag = "R3 window"; end
      2'd1: begin exp = 32'(mCnt); tag = "R4 count"; end
      2'd2: begin exp = {31'd0, mFlag}; tag = "R7 status"; end
      default: begin exp = 32'd0; tag = "R9 unused read"; end
    endcase
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic step(input bit w, input logic [1:0] a, input logic [31:0] d);
    regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    compare();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic run(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      if (i % half == 0) oscIn = ~oscIn;
      step(1'b0, 2'(i % 4), 32'd0);
    end
  endtask

  initial begin
    logic [31:0] v, c0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(2'd0, v); check(v == 0, "R1 window", v, 0);
    rd(2'd1, v); check(v == 0, "R1 count", v, 0);
    rd(2'd2, v); check(v == 0, "R1 status", v, 0);

    step(1'b1, 2'd0, 32'd40);
    run(60, 2);

    // R2 upper bits ignored
    step(1'b1, 2'd0, 32'hFFFF_FC05);
    rd(2'd0, v); check(v == 32'd5, "R2 truncated load", v, 5);
    rd(2'd1, v); check(v == 0, "R8 count cleared", v, 0);
    run(20, 1);
    rd(2'd0, v); check(v == 0, "R3 hold at zero", v, 0);

    // R9 writes elsewhere ignored
    rd(2'd1, c0);
    step(1'b1, 2'd1, 32'h77);
    step(1'b1, 2'd2, 32'h1);
    step(1'b1, 2'd3, 32'hFF);
    rd(2'd1, v); check(v == c0, "R9 count untouched", v, c0);
    rd(2'd0, v); check(v == 0, "R9 window untouched", v, 0);

    // R6 / R7 saturation and threshold
    step(1'b1, 2'd0, 32'd300);
    run(290, 1);
    rd(2'd1, v); check(v == CNT_MX, "R6 saturated", v, CNT_MX);
    rd(2'd2, v); check(v == 1, "R7 flag set", v, 1);
    run(20, 1);
    rd(2'd2, v); check(v == 1, "R7 flag sticky", v, 1);

    // R8 restart in the middle of a measurement
    step(1'b1, 2'd0, 32'd500);
    run(30, 1);
    step(1'b1, 2'd0, 32'd500);
    rd(2'd1, v); check(v == 0, "R8 restart count", v, 0);
    rd(2'd2, v); check(v == 0, "R8 restart flag", v, 0);

    // R5 synchronizer latency
    oscIn = 1'b0;
    repeat (4) step(1'b0, 2'd1, 32'd0);
    rd(2'd1, c0);
    oscIn = 1'b1;
    step(1'b0, 2'd1, 32'd0);
    step(1'b0, 2'd1, 32'd0);
    rd(2'd1, v); check(v == c0, "R5 not yet counted", v, c0);
    step(1'b0, 2'd1, 32'd0);
    rd(2'd1, v); check(v == c0 + 1, "R5 counted on third edge", v, c0 + 1);

    // R4 closed window counts nothing
    step(1'b1, 2'd0, 32'd0);
    run(30, 1);
    rd(2'd1, v); check(v == 0, "R4 no count with zero window", v, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule